// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two K-bit operands over K clock cycles and returns a 2K-bit product. It retires one bit of the multiplier per cycle. The partial product is kept as a double-width pair: a high half, and a low half that starts out holding the multiplier. In each step the low bit of the low half picks either zero or the multiplicand as the addend. The sum is then written back already shifted one place to the right, so the add and the shift happen in a single register load.

The same datapath handles unsigned and two's-complement operands. In signed mode, both adder inputs are sign-extended to K+1 bits, so the shifted-in top bit is the true sign of the partial product. The final step subtracts instead of adding, because the top multiplier bit has negative weight. The adder is a K+1 bit ripple chain. It subtracts by inverting the addend and forcing the carry-in to one.

The input side follows a valid/ready rule. `start` acts as valid and `!busy` acts as ready, so a request is taken only on a clock edge where `start` is high and `busy` is low. While `busy` is high, any `start` is dropped. The operands and the mode are captured at acceptance. The output side has no back-pressure. `done` is a one-cycle pulse, and `product` holds its value until the next request is accepted.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is held and after it is released with no request, `busy`, `done` and `product` are all zero.
- R2: A request is accepted at an edge where `start` is 1 and `busy` is 0, and `busy` is 1 from the next cycle for exactly K cycles.
- R3: `done` is 1 for exactly one cycle, in the cycle where `busy` returns to 0, K cycles after the first busy cycle.
- R4: With `signed_mode` = 0 at acceptance, `product` at `done` equals the unsigned product of `op_a` and `op_b`.
- R5: With `signed_mode` = 1 at acceptance, `product` at `done` equals the two's-complement product of `op_a` and `op_b`, read as a 2K-bit signed value.
- R6: A `start` raised while `busy` is 1 is ignored, and neither the completion time nor the result changes.
- R7: While idle and with no request, `product` keeps the last result.
- R8: Corner operands give exact results: the most negative value times itself, the largest unsigned values, zero, and (for K = 4, signed) 1010×0011 = 11101110 and 1010×1011 = 00011110.
- R9: Changes to `op_a`, `op_b` or `signed_mode` after acceptance do not affect the running result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request valid; accepted when busy is 0 |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_a | input | K | Multiplicand |
| op_b | input | K | Multiplier |
| busy | output | 1 | Multiplication in progress; inverse of input ready |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2K | Result, held until the next accepted request |

## Verification
The assertions assume that `start` is a synchronous level which changes only away from the rising edge, and that reset is applied from time zero. They also assume the mode and operands are meaningful only at the edge where a request is accepted. The bench drives every input on the falling edge and samples on the falling edge. It perturbs the operands, the mode and `start` only while `busy` is high, so the claims about ignored inputs are tested inside those assumptions.

// File: rtl/mulsa_pkg.sv
package mulsa_pkg;
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mul_mode_e;
endpackage

// File: rtl/mulsa_ctrl.sv
module mulsa_ctrl #(
  parameter int K = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step,
  output logic last_step,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(K + 1);

  logic [CW-1:0] count;

  assign busy      = (count != '0);
  assign step      = busy;
  assign last_step = (count == CW'(1));
  assign accept    = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
    end else begin
      if (accept)    count <= CW'(K);
      else if (busy) count <= count - CW'(1);
      done <= last_step;
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/mulsa_addsub.sv
module mulsa_addsub #(
  parameter int W = 9
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum
);
  logic [W:0]   carry;
  logic [W-1:0] b_eff;

  assign carry[0] = sub;
  assign b_eff    = b ^ {W{sub}};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
  end
endmodule

// File: rtl/mulsa_datapath.sv
module mulsa_datapath
  import mulsa_pkg::*;
#(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         last_step,
  input  logic         signed_in,
  input  logic [K-1:0] a_in,
  input  logic [K-1:0] b_in,
  output logic [2*K-1:0] product
);
  localparam int W = K + 1;

  mul_mode_e    mode_q;
  logic [K-1:0] mcand;
  logic [K-1:0] hi;
  logic [K-1:0] lo;
  logic [W-1:0] hi_ext;
  logic [W-1:0] mcand_ext;
  logic [W-1:0] addend;
  logic [W-1:0] sum;
  logic         sgn;
  logic         sub;

  assign sgn       = (mode_q == MODE_SIGNED);
  assign hi_ext    = {sgn & hi[K-1], hi};
  assign mcand_ext = {sgn & mcand[K-1], mcand};
  assign addend    = lo[0] ? mcand_ext : '0;
  assign sub       = sgn && last_step;

  mulsa_addsub #(.W(W)) u_addsub (
    .a   (hi_ext),
    .b   (addend),
    .sub (sub),
    .sum (sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_UNSIGNED;
      mcand  <= '0;
      hi     <= '0;
      lo     <= '0;
    end else if (load) begin
      mode_q <= mul_mode_e'(signed_in);
      mcand  <= a_in;
      hi     <= '0;
      lo     <= b_in;
    end else if (step) begin
      hi <= sum[W-1:1];
      lo <= {sum[0], lo[K-1:1]};
    end
  end

  assign product = {hi, lo};

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(product));
  // R9
  mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ($stable(mcand) && $stable(mode_q)));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int K = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           signed_mode,
  input  logic [K-1:0]   op_a,
  input  logic [K-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*K-1:0] product
);
  logic accept;
  logic step;
  logic last_step;

  mulsa_ctrl #(.K(K)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .step      (step),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  mulsa_datapath #(.K(K)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .step      (step),
    .last_step (last_step),
    .signed_in (signed_mode),
    .a_in      (op_a),
    .b_in      (op_b),
    .product   (product)
  );

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done));
endmodule

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;
  localparam int K = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic smode = 1'b0;
  logic [K-1:0] a = '0;
  logic [K-1:0] b = '0;
  logic busy;
  logic done;
  logic [2*K-1:0] prod;

  logic start4 = 1'b0;
  logic smode4 = 1'b0;
  logic [3:0] a4 = '0;
  logic [3:0] b4 = '0;
  logic busy4;
  logic done4;
  logic [7:0] prod4;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  shift_add_mul #(.K(K)) u_shift_add_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(smode),
    .op_a(a), .op_b(b), .busy(busy), .done(done), .product(prod)
  );

  shift_add_mul #(.K(4)) u_shift_add_mul_k4 (
    .clk(clk), .rst_n(rst_n), .start(start4), .signed_mode(smode4),
    .op_a(a4), .op_b(b4), .busy(busy4), .done(done4), .product(prod4)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*K-1:0] expect_prod(input logic [K-1:0] x, input logic [K-1:0] y,
                                                 input logic s);
    logic signed [2*K-1:0] sx;
    logic signed [2*K-1:0] sy;
    if (s) begin
      sx = (2*K)'($signed(x));
      sy = (2*K)'($signed(y));
      return sx * sy;
    end
    return {{K{1'b0}}, x} * {{K{1'b0}}, y};
  endfunction

  // One multiplication on the K-bit instance; perturb exercises R6 and R9.
  task automatic run_mul(input logic [K-1:0] x, input logic [K-1:0] y, input logic s,
                         input bit perturb, input string tag);
    logic [2*K-1:0] exp;
    logic [2*K-1:0] held;
    int n;
    exp = expect_prod(x, y, s);
    @(negedge clk);
    a = x; b = y; smode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after accept", longint'(busy), 1);
    if (perturb) begin
      a = ~x; b = y ^ 8'h5a; smode = ~s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R6 busy during ignored start", longint'(busy), 1);
      n = 2;
    end else begin
      n = 1;
    end
    while (done !== 1'b1 && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(n == K + 1, {"R3 latency ", tag}, longint'(n - 1), longint'(K));
    check(busy === 1'b0, "R3 busy low at done", longint'(busy), 0);
    check(prod === exp, {s ? "R5 " : "R4 ", tag}, longint'(prod), longint'(exp));
    held = prod;
    @(negedge clk);
    check(done === 1'b0, "R3 done single cycle", longint'(done), 0);
    a = ~a; b = ~b;
    repeat (2) @(negedge clk);
    check(prod === held, "R7 product held while idle", longint'(prod), longint'(held));
    check(busy === 1'b0, "R6 no extra run", longint'(busy), 0);
  endtask

  task automatic run_k4(input logic [3:0] x, input logic [3:0] y, input logic [7:0] exp);
    int n;
    @(negedge clk);
    a4 = x; b4 = y; smode4 = 1'b1; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    n = 1;
    while (done4 !== 1'b1 && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == 5, "R3 latency k4", longint'(n - 1), 4);
    check(prod4 === exp, "R8 k4 signed example", longint'(prod4), longint'(exp));
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 busy in reset", longint'(busy), 0);
    check(done === 1'b0, "R1 done in reset", longint'(done), 0);
    check(prod === '0, "R1 product in reset", longint'(prod), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 idle after reset", longint'({busy, done}), 0);
    check(prod === '0, "R1 product after reset", longint'(prod), 0);
  endtask

  task automatic test_unsigned();
    run_mul(8'd13, 8'd11, 1'b0, 1'b0, "u small");
    run_mul(8'hff, 8'hff, 1'b0, 1'b0, "R8 u max");
    run_mul(8'h00, 8'hc3, 1'b0, 1'b0, "R8 u zero");
    run_mul(8'h80, 8'h02, 1'b0, 1'b0, "u msb");
  endtask

  task automatic test_signed();
    run_mul(8'hfa, 8'h03, 1'b1, 1'b0, "s neg*pos");
    run_mul(8'hfa, 8'hf5, 1'b1, 1'b0, "s neg*neg");
    run_mul(8'h07, 8'h85, 1'b1, 1'b0, "s pos*neg");
    run_mul(8'h80, 8'h80, 1'b1, 1'b0, "R8 s min*min");
    run_mul(8'h7f, 8'h80, 1'b1, 1'b0, "R8 s max*min");
  endtask

  task automatic test_ignored();
    run_mul(8'h9c, 8'h37, 1'b0, 1'b1, "R9 u perturbed");
    run_mul(8'h9c, 8'hb7, 1'b1, 1'b1, "R9 s perturbed");
  endtask

  task automatic test_k4();
    run_k4(4'b1010, 4'b0011, 8'b11101110);
    run_k4(4'b1010, 4'b1011, 8'b00011110);
  endtask

  task automatic test_sweep();
    for (int i = 0; i < 12; i++) begin
      run_mul(8'(i * 37 + 5), 8'(i * 91 + 200), 1'(i % 2), 1'b0, "sweep");
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    test_reset();
    test_unsigned();
    test_signed();
    test_ignored();
    test_k4();
    test_sweep();
    finish_run();
  end
endmodule